// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block stamps external events with the value of a free-running 16-bit counter. One of two event inputs is chosen: a capture pin, or the digital output of an analog comparator. The chosen input is synchronised and can optionally be passed through a noise filter. An edge detector then looks for the chosen edge direction. When that edge is found, the counter value is stored in a 16-bit capture register. In the same clock cycle a capture flag is set, and this flag can raise an interrupt request.

Software reaches the capture register through an 8-bit bus and a shared high-byte holding latch. A 16-bit read reads the low byte first. That read loads the holding latch with the matching high byte, so the two bytes always belong to the same capture. A 16-bit write goes the other way: the high byte is written first into the latch, and the low-byte write commits both bytes. The commit only happens when the timer's waveform mode uses the capture register as its period limit. The flag clears on an interrupt acknowledge or when software writes a one to it.

Top module: `evt_capture_top`

## Requirements
- R1: `cnt_o` is 0 during reset. It increments by one on every clock and wraps from 16'hFFFF to 0.
- R2: `src_cmp_i`=1 selects `cmp_out_i` as the event input and `src_cmp_i`=0 selects `cap_pin_i`. Level changes on the input that is not selected cause no capture.
- R3: `edge_rise_i`=1 captures on a 0-to-1 change of the filtered input and `edge_rise_i`=0 captures on a 1-to-0 change. The opposite change causes no capture.
- R4: With the filter off, an input change applied in the cycle where `cnt_o` shows value v is captured as v+2. It is readable from the cycle after the third rising clock edge that follows the change.
- R5: The capture flag is set on the same clock edge that loads the capture register. The flag reads as bit 0 at bus address 2, and the other bits read 0.
- R6: With `filt_en_i`=1, a level change passes only after 4 consecutive equal synchronised samples. This delays the capture by 4 cycles (the value becomes v+6), and a pulse shorter than 4 cycles is never captured.
- R7: `irq_o` is 1 exactly while the flag is set and `irq_en_i`=1. An `irq_ack_i` pulse clears the flag.
- R8: A bus write to address 2 with data bit 0 set clears the flag. A write with bit 0 clear leaves the flag unchanged. When a capture and a clear fall in the same cycle, the flag stays set.
- R9: Reading address 0 returns the low byte of the capture register and copies its high byte into the holding latch. Reading address 1 returns the holding latch, so a capture between the two reads does not split the 16-bit value.
- R10: Writing address 1 loads the holding latch. Writing address 0 stores {latch, data} into the capture register only when `top_mode_i`=1; otherwise the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin_i | input | 1 | External capture pin |
| cmp_out_i | input | 1 | Analog comparator digital output |
| src_cmp_i | input | 1 | 1 selects the comparator, 0 selects the pin |
| filt_en_i | input | 1 | Enables the noise filter |
| edge_rise_i | input | 1 | 1 = rising edge, 0 = falling edge |
| top_mode_i | input | 1 | Waveform mode uses the capture register as period limit (write enable) |
| irq_en_i | input | 1 | Capture interrupt enable |
| irq_ack_i | input | 1 | Interrupt serviced, clears the flag |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_addr_i | input | 2 | 0 = capture low, 1 = capture high / latch, 2 = flag |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Bus read data (combinational from address) |
| cnt_o | output | 16 | Free-running counter value |
| irq_o | output | 1 | Interrupt request |

## Verification
An input change applied after clock edge e is captured at edge e+3 when the filter is off, and at edge e+7 when it is on. The flag and interrupt are visible from the following half cycle. Bus read data follows the address within the same cycle, while the latch and register updates from a bus access appear after the next edge. The bench drives every input at the falling edge. It advances a behavioural reference on each rising edge and compares the outputs a few nanoseconds after the next falling edge. The directed checks therefore read the capture register only after the edge on which the capture is due.

// File: rtl/evt_capture_pkg.sv
package evt_capture_pkg;

    // Bus address map of the capture unit
    typedef enum logic [1:0] {
        SEL_CAP_LO = 2'd0,
        SEL_CAP_HI = 2'd1,
        SEL_FLAG   = 2'd2,
        SEL_NONE   = 2'd3
    } bus_sel_e;

    // Position of the capture flag inside the flag byte
    localparam int FLAG_BIT = 0;

endpackage

// File: rtl/evt_free_cnt.sv
module evt_free_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/evt_front.sv
module evt_front #(
    parameter int SYNC_LEN = 2,
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_pin_i,
    input  logic cmp_out_i,
    input  logic src_cmp_i,
    input  logic filt_en_i,
    input  logic edge_rise_i,
    output logic cap_stb_o
);

    localparam int SYNC_TOP = SYNC_LEN - 1;
    localparam int HIST_TOP = FILT_LEN - 1;

    typedef struct packed {
        logic [SYNC_LEN-1:0] sync;
        logic [FILT_LEN-1:0] hist;
        logic                lvl;
    } front_st_t;

    front_st_t st_d, st_q;
    logic      src_raw;
    logic      sync_out;
    logic      hist_ones;
    logic      hist_zeros;
    logic      lvl_nxt;

    // Source select: comparator output or external pin
    assign src_raw  = src_cmp_i ? cmp_out_i : cap_pin_i;
    assign sync_out = st_q.sync[SYNC_TOP];

    // Synchroniser chain; element 0 is the first flop
    generate
        if (SYNC_LEN > 1) begin : g_sync_chain
            always_comb begin
                st_d.sync = {st_q.sync[SYNC_TOP-1:0], src_raw};
            end
        end else begin : g_sync_single
            always_comb begin
                st_d.sync = src_raw;
            end
        end
    endgenerate

    // Filter history; element 0 holds the newest synchronised sample
    generate
        if (FILT_LEN > 1) begin : g_hist_chain
            always_comb begin
                st_d.hist = {st_q.hist[HIST_TOP-1:0], sync_out};
            end
        end else begin : g_hist_single
            always_comb begin
                st_d.hist = sync_out;
            end
        end
    endgenerate

    assign hist_ones  = &st_q.hist;
    assign hist_zeros = ~|st_q.hist;

    always_comb begin
        if (filt_en_i) begin
            if (hist_ones) begin
                lvl_nxt = 1'b1;
            end else if (hist_zeros) begin
                lvl_nxt = 1'b0;
            end else begin
                lvl_nxt = st_q.lvl;
            end
        end else begin
            lvl_nxt = sync_out;
        end
        st_d.lvl = lvl_nxt;
    end

    // Edge qualifier: level changes this cycle in the selected direction
    assign cap_stb_o = (lvl_nxt != st_q.lvl) && (lvl_nxt == edge_rise_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/evt_cap_regs.sv
module evt_cap_regs
    import evt_capture_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cap_stb_i,
    input  logic             top_mode_i,
    input  logic             irq_en_i,
    input  logic             irq_ack_i,
    input  logic             bus_rd_i,
    input  logic             bus_wr_i,
    input  logic [1:0]       bus_addr_i,
    input  logic [BUS_W-1:0] bus_wdata_i,
    output logic [BUS_W-1:0] bus_rdata_o,
    output logic             irq_o,
    output logic [CNT_W-1:0] cap_o,
    output logic             flag_o
);

    localparam int HI_W = CNT_W - BUS_W;

    typedef struct packed {
        logic [CNT_W-1:0] cap;
        logic [HI_W-1:0]  temp;
        logic             flag;
    } regs_st_t;

    regs_st_t st_d, st_q;
    logic     rd_lo;
    logic     wr_lo;
    logic     wr_hi;
    logic     wr_flag;

    assign rd_lo   = bus_rd_i && (bus_addr_i == SEL_CAP_LO);
    assign wr_lo   = bus_wr_i && (bus_addr_i == SEL_CAP_LO);
    assign wr_hi   = bus_wr_i && (bus_addr_i == SEL_CAP_HI);
    assign wr_flag = bus_wr_i && (bus_addr_i == SEL_FLAG);

    always_comb begin
        st_d = st_q;

        // Shared high-byte latch: written directly, or loaded by a low read
        if (wr_hi) begin
            st_d.temp = bus_wdata_i[HI_W-1:0];
        end else if (rd_lo) begin
            st_d.temp = st_q.cap[CNT_W-1:BUS_W];
        end

        // Capture has priority over a software write
        if (cap_stb_i) begin
            st_d.cap = cnt_i;
        end else if (wr_lo && top_mode_i) begin
            st_d.cap = {st_q.temp, bus_wdata_i};
        end

        // Flag: capture wins over both clear sources
        if (cap_stb_i) begin
            st_d.flag = 1'b1;
        end else if (irq_ack_i || (wr_flag && bus_wdata_i[FLAG_BIT])) begin
            st_d.flag = 1'b0;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            SEL_CAP_LO: bus_rdata_o = st_q.cap[BUS_W-1:0];
            SEL_CAP_HI: bus_rdata_o = BUS_W'(st_q.temp);
            SEL_FLAG:   bus_rdata_o[FLAG_BIT] = st_q.flag;
            default:    bus_rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o  = st_q.flag && irq_en_i;
    assign cap_o  = st_q.cap;
    assign flag_o = st_q.flag;

endmodule

// File: rtl/evt_capture_top.sv
module evt_capture_top #(
    parameter int CNT_W    = 16,
    parameter int BUS_W    = 8,
    parameter int SYNC_LEN = 2,
    parameter int FILT_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pin_i,
    input  logic             cmp_out_i,
    input  logic             src_cmp_i,
    input  logic             filt_en_i,
    input  logic             edge_rise_i,
    input  logic             top_mode_i,
    input  logic             irq_en_i,
    input  logic             irq_ack_i,
    input  logic             bus_rd_i,
    input  logic             bus_wr_i,
    input  logic [1:0]       bus_addr_i,
    input  logic [BUS_W-1:0] bus_wdata_i,
    output logic [BUS_W-1:0] bus_rdata_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o
);

    logic [CNT_W-1:0] cnt_w;
    logic             cap_stb_w;
    logic [CNT_W-1:0] cap_val_w;
    logic             flag_w;

    evt_free_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_o (cnt_w)
    );

    evt_front #(
        .SYNC_LEN (SYNC_LEN),
        .FILT_LEN (FILT_LEN)
    ) u_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_pin_i   (cap_pin_i),
        .cmp_out_i   (cmp_out_i),
        .src_cmp_i   (src_cmp_i),
        .filt_en_i   (filt_en_i),
        .edge_rise_i (edge_rise_i),
        .cap_stb_o   (cap_stb_w)
    );

    evt_cap_regs #(
        .CNT_W (CNT_W),
        .BUS_W (BUS_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_i       (cnt_w),
        .cap_stb_i   (cap_stb_w),
        .top_mode_i  (top_mode_i),
        .irq_en_i    (irq_en_i),
        .irq_ack_i   (irq_ack_i),
        .bus_rd_i    (bus_rd_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_o),
        .cap_o       (cap_val_w),
        .flag_o      (flag_w)
    );

    assign cnt_o = cnt_w;

endmodule

// File: rtl/evt_capture_chk.sv
module evt_capture_chk
    import evt_capture_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic             cap_stb,
    input logic [CNT_W-1:0] cap_val,
    input logic             flag,
    input logic             irq_ack_i,
    input logic             bus_wr_i,
    input logic [1:0]       bus_addr_i,
    input logic [BUS_W-1:0] bus_wdata_i,
    input logic             top_mode_i
);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt == CNT_W'($past(cnt) + CNT_W'(1))); // R1

    AST_CAP_TAKES_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |=> cap_val == $past(cnt)); // R4

    AST_FLAG_WITH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |=> flag); // R5

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && !cap_stb) |=> !flag); // R7

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == SEL_FLAG && bus_wdata_i[FLAG_BIT] && !cap_stb) |=> !flag); // R8

    AST_CAP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == SEL_CAP_LO && !top_mode_i && !cap_stb) |=> $stable(cap_val)); // R10

endmodule

bind evt_capture_top evt_capture_chk #(
    .CNT_W (CNT_W),
    .BUS_W (BUS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt         (cnt_w),
    .cap_stb     (cap_stb_w),
    .cap_val     (cap_val_w),
    .flag        (flag_w),
    .irq_ack_i   (irq_ack_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .top_mode_i  (top_mode_i)
);

// File: tb/evt_capture_top_bench.sv
module evt_capture_top_bench;

    localparam int F = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_pin_i = 1'b0;
    logic        cmp_out_i = 1'b0;
    logic        src_cmp_i = 1'b0;
    logic        filt_en_i = 1'b0;
    logic        edge_rise_i = 1'b1;
    logic        top_mode_i = 1'b0;
    logic        irq_en_i = 1'b0;
    logic        irq_ack_i = 1'b0;
    logic        bus_rd_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [1:0]  bus_addr_i = 2'd3;
    logic [7:0]  bus_wdata_i = 8'h00;
    logic [7:0]  bus_rdata_o;
    logic [15:0] cnt_o;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    evt_capture_top u_evt_capture_top (
        .clk(clk), .rst_n(rst_n), .cap_pin_i(cap_pin_i), .cmp_out_i(cmp_out_i),
        .src_cmp_i(src_cmp_i), .filt_en_i(filt_en_i), .edge_rise_i(edge_rise_i),
        .top_mode_i(top_mode_i), .irq_en_i(irq_en_i), .irq_ack_i(irq_ack_i),
        .bus_rd_i(bus_rd_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .cnt_o(cnt_o), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Behavioural reference: delay line of samples plus a run-length filter
    logic        m_s1, m_s2, m_last, m_lvl, m_flag;
    int          m_run;
    logic [15:0] m_cnt, m_cap;
    logic [7:0]  m_temp;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_last = 0; m_lvl = 0; m_flag = 0;
            m_run = F; m_cnt = 0; m_cap = 0; m_temp = 0;
        end else begin
            logic src, lvl_n, evt;
            src   = src_cmp_i ? cmp_out_i : cap_pin_i;
            lvl_n = filt_en_i ? ((m_run >= F) ? m_last : m_lvl) : m_s2;
            evt   = (lvl_n != m_lvl) && (lvl_n == edge_rise_i);
            if (bus_wr_i && bus_addr_i == 2'd1) m_temp = bus_wdata_i;
            else if (bus_rd_i && bus_addr_i == 2'd0) m_temp = m_cap[15:8];
            if (evt) m_cap = m_cnt;
            else if (bus_wr_i && bus_addr_i == 2'd0 && top_mode_i) m_cap = {m_temp, bus_wdata_i};
            if (evt) m_flag = 1;
            else if (irq_ack_i || (bus_wr_i && bus_addr_i == 2'd2 && bus_wdata_i[0])) m_flag = 0;
            m_run  = (m_s2 == m_last) ? ((m_run >= F) ? F : m_run + 1) : 1;
            m_last = m_s2;
            m_s2   = m_s1;
            m_s1   = src;
            m_lvl  = lvl_n;
            m_cnt  = m_cnt + 16'd1;
        end
    end

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        #4;
        if (rst_n && !done) begin
            logic [7:0] exp_rd;
            case (bus_addr_i)
                2'd0: exp_rd = m_cap[7:0];
                2'd1: exp_rd = m_temp;
                2'd2: exp_rd = {7'd0, m_flag};
                default: exp_rd = 8'd0;
            endcase
            chk(cnt_o == m_cnt, "R1 counter", cnt_o, m_cnt);
            chk(irq_o == (m_flag && irq_en_i), "R7 irq", irq_o, m_flag && irq_en_i);
            chk(bus_rdata_o == exp_rd, "R9 read data", bus_rdata_o, exp_rd);
        end
    end

    task automatic bus_op(input bit rd, input bit wr, input logic [1:0] a,
                          input logic [7:0] wd, output logic [7:0] rdv);
        @(negedge clk);
        bus_rd_i = rd; bus_wr_i = wr; bus_addr_i = a; bus_wdata_i = wd;
        #2 rdv = bus_rdata_o;
        @(posedge clk);
        #1 bus_rd_i = 0; bus_wr_i = 0; bus_addr_i = 2'd3;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        bus_op(1, 0, 2'd0, 8'h00, lo);
        bus_op(1, 0, 2'd1, 8'h00, hi);
        v = {hi, lo};
    endtask

    task automatic rd_flag(output logic f);
        logic [7:0] r;
        bus_op(1, 0, 2'd2, 8'h00, r);
        f = r[0];
    endtask

    task automatic clr_flag();
        logic [7:0] r;
        bus_op(0, 1, 2'd2, 8'h01, r);
    endtask

    initial begin
        logic [15:0] v, d, cap_ref;
        logic [7:0]  r;
        logic        f;

        repeat (3) @(negedge clk);
        chk(cnt_o == 16'd0, "R1 reset count", cnt_o, 0);
        chk(irq_o == 1'b0, "R7 reset irq", irq_o, 0);
        rst_n = 1'b1;
        rd16(v);
        chk(v == 16'd0, "R9 reset capture", v, 0);

        // R4/R5: unfiltered rising capture on the pin
        @(negedge clk); d = cnt_o; cap_pin_i = 1;
        repeat (3) @(posedge clk);
        rd_flag(f);
        chk(f == 1'b1, "R5 flag after capture", f, 1);
        rd16(v);
        chk(v == d + 16'd2, "R4 capture value", v, d + 16'd2);
        cap_ref = v;
        clr_flag();
        rd_flag(f);
        chk(f == 1'b0, "R8 write one clears", f, 0);

        // R3: falling change with rising select is ignored
        @(negedge clk); cap_pin_i = 0;
        repeat (6) @(posedge clk);
        rd_flag(f);
        chk(f == 1'b0, "R3 wrong edge no flag", f, 0);
        rd16(v);
        chk(v == cap_ref, "R3 wrong edge keeps value", v, cap_ref);

        // R3: falling select captures the falling change
        edge_rise_i = 0;
        @(negedge clk); cap_pin_i = 1;
        repeat (6) @(posedge clk);
        @(negedge clk); d = cnt_o; cap_pin_i = 0;
        repeat (3) @(posedge clk);
        rd16(v);
        chk(v == d + 16'd2, "R3 falling capture", v, d + 16'd2);
        clr_flag();
        edge_rise_i = 1;

        // R2: comparator toggles ignored while pin is selected
        @(negedge clk); cmp_out_i = 1;
        repeat (6) @(posedge clk);
        rd_flag(f);
        chk(f == 1'b0, "R2 unselected source ignored", f, 0);
        @(negedge clk); cmp_out_i = 0;
        repeat (6) @(posedge clk);
        src_cmp_i = 1;
        @(negedge clk); d = cnt_o; cmp_out_i = 1;
        repeat (3) @(posedge clk);
        rd16(v);
        chk(v == d + 16'd2, "R2 comparator capture", v, d + 16'd2);
        clr_flag();
        @(negedge clk); cmp_out_i = 0;
        repeat (6) @(posedge clk);
        src_cmp_i = 0;

        // R6: filtered, short pulse rejected then held level captured
        filt_en_i = 1;
        repeat (8) @(posedge clk);
        @(negedge clk); cap_pin_i = 1;
        repeat (3) @(negedge clk); cap_pin_i = 0;
        repeat (10) @(posedge clk);
        rd_flag(f);
        chk(f == 1'b0, "R6 short pulse rejected", f, 0);
        @(negedge clk); d = cnt_o; cap_pin_i = 1;
        repeat (7) @(posedge clk);
        rd16(v);
        chk(v == d + 16'd6, "R6 filtered capture", v, d + 16'd6);

        // R7: interrupt and acknowledge
        irq_en_i = 1;
        @(negedge clk); #4;
        chk(irq_o == 1'b1, "R7 irq raised", irq_o, 1);
        @(negedge clk); irq_ack_i = 1;
        @(negedge clk); irq_ack_i = 0; #4;
        chk(irq_o == 1'b0, "R7 ack clears", irq_o, 0);
        filt_en_i = 0;
        @(negedge clk); cap_pin_i = 0;
        repeat (6) @(posedge clk);

        // R8: write of zero leaves flag; capture beats clear in the same cycle
        @(negedge clk); cap_pin_i = 1;
        repeat (4) @(posedge clk);
        bus_op(0, 1, 2'd2, 8'h00, r);
        rd_flag(f);
        chk(f == 1'b1, "R8 zero write keeps flag", f, 1);
        clr_flag();
        @(negedge clk); cap_pin_i = 0;
        repeat (6) @(posedge clk);
        @(negedge clk); cap_pin_i = 1;
        @(posedge clk); @(posedge clk);
        bus_op(0, 1, 2'd2, 8'h01, r);
        rd_flag(f);
        chk(f == 1'b1, "R8 capture wins over clear", f, 1);
        clr_flag();
        rd16(cap_ref);

        // R10: write locked without top mode, committed with it
        bus_op(0, 1, 2'd1, 8'hAB, r);
        bus_op(0, 1, 2'd0, 8'hCD, r);
        rd16(v);
        chk(v == cap_ref, "R10 write ignored", v, cap_ref);
        top_mode_i = 1;
        bus_op(0, 1, 2'd1, 8'hAB, r);
        bus_op(0, 1, 2'd0, 8'hCD, r);
        top_mode_i = 0;
        rd16(v);
        chk(v == 16'hABCD, "R10 write committed", v, 16'hABCD);

        // R9: capture between low and high reads does not split the value
        @(negedge clk); cap_pin_i = 0;
        repeat (6) @(posedge clk);
        bus_op(1, 0, 2'd0, 8'h00, r);
        chk(r == 8'hCD, "R9 low byte", r, 8'hCD);
        @(negedge clk); cap_pin_i = 1;
        repeat (4) @(posedge clk);
        bus_op(1, 0, 2'd1, 8'h00, r);
        chk(r == 8'hAB, "R9 latched high byte", r, 8'hAB);

        // R1: wrap
        while (cnt_o != 16'hFFFF) @(negedge clk);
        @(negedge clk); #4;
        chk(cnt_o == 16'h0000, "R1 wrap", cnt_o, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule